// File: doc/BRIEF.md
# USB Endpoint Receive Handshake Controller

This block keeps the receive-side control word for endpoint 0 and up to two further endpoints of a USB device. A packet engine reports each finished OUT or SETUP transaction as a one-cycle event. The event carries the token kind, the token's endpoint number, the received data PID and a flag that says whether the packet passed its checks. The block routes the event to the endpoint whose address field matches. It then picks the handshake to send back (none, ACK, NAK or STALL) and updates that endpoint's toggle and status bits.

Software reads and writes the control words through a small register port. Hardware owns the toggle and status bits whenever a transaction completes. After a correct transfer, hardware parks the endpoint in NAK and raises a sticky correct-transfer flag. That gives software time to drain the data before it re-arms the endpoint. A USB bus reset returns every control word to its reset value.

Each control word is 8 bits wide:

| Bits | Meaning |
|------|---------|
| 7 | control-endpoint flag |
| 6 | expected receive toggle (0 = DATA0, 1 = DATA1) |
| 5:4 | receive status |
| 3:0 | endpoint address |

Register port addresses: 0, 1 and 2 select the endpoint words, and 3 is the correct-transfer flag word.

Top module: `usb_rx_hs_ctrl`

## Requirements
- R1: After system reset, endpoint 0 reads 0x80, endpoints 1 and 2 read 0x00, the flag word (address 3) reads 0x00 and `hs_valid_o` is 0.
- R2: Endpoint 0 always reads 1 in bit 7 and 0 in bits 3:0. Writes to those bits are ignored, while bits 6:4 take the written value.
- R3: `hs_valid_o` pulses for one cycle in the cycle after each `xact_end_i`, and `hs_o` and `ep_idx_o` are valid with it. The `hs_o` encoding is 00 none, 01 ACK, 10 NAK, 11 STALL. For a good OUT packet, the status picks the reply: 00 (off) gives none, 01 gives STALL, 10 gives NAK, 11 (valid) gives ACK.
- R4: A good OUT packet on a valid endpoint whose data PID equals the expected toggle gets ACK. It flips the toggle, sets the status to 10 (NAK) and sets the correct-transfer flag.
- R5: A good OUT packet on a valid endpoint whose data PID differs from the expected toggle gets ACK. The toggle, the status and the flag stay unchanged.
- R6: A good SETUP packet on an endpoint with bit 7 set and a status other than 00 gets ACK. With DATA0 (PID bit 0), the toggle ends at 1, the status becomes NAK and the flag is set. With DATA1, the toggle is cleared to 0 and nothing else changes. A SETUP packet on an endpoint with bit 7 clear gets no handshake and changes nothing.
- R7: A packet with `pkt_good_i` low gets no handshake and changes no register or flag.
- R8: A token goes to the present endpoint whose bits 3:0 equal `tok_ep_i`, and the lowest index wins when several match. With no match, the reply is none and `ep_idx_o` is 0. With a match, `ep_idx_o` gives the matched index.
- R9: `bus_rst_i` restores the R1 values of all control words and clears the flag.
- R10: When a CPU write and a hardware update hit the same word in one cycle, hardware sets bits 6:4 and the write sets the remaining bits.
- R11: Address 3 reads the flag in bit 0. The flag stays set until a write to address 3, and a set in the same cycle wins over the clear.
- R12: With `HAS_EP2` = 0, address 2 reads 0x00 and endpoint 2 never matches a token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low system reset |
| bus_rst_i | input | 1 | USB bus reset strobe |
| reg_we_i | input | 1 | register write enable |
| reg_addr_i | input | 2 | register select: 0 to 2 endpoint words, 3 flag word |
| reg_wdata_i | input | 8 | register write data |
| reg_rdata_o | output | 8 | register read data, combinational |
| xact_end_i | input | 1 | transaction end strobe from the packet engine |
| tok_setup_i | input | 1 | 1 = SETUP token, 0 = OUT token |
| tok_ep_i | input | 4 | token endpoint number |
| pid_data1_i | input | 1 | data PID: 0 = DATA0, 1 = DATA1 |
| pkt_good_i | input | 1 | packet passed its checks |
| hs_valid_o | output | 1 | handshake decision valid |
| hs_o | output | 2 | handshake choice |
| ep_idx_o | output | 2 | matched endpoint index |
| ctr_o | output | 1 | sticky correct-transfer flag |

## Verification
The main table drives OUT events against each of the four status codes, and drives matching and non-matching data PIDs on a valid endpoint. This separates the reply lookup from the toggle comparison. SETUP events go to control and non-control endpoints with both PIDs, which tells the toggle clear apart from the later toggle advance. Corrupt packets, unmatched addresses and two endpoints sharing one address show that nothing is written on those paths and that the lowest index wins. Directed cases then cover a write and a hardware update landing together, a flag set racing a flag clear, a bus reset, and a build without the third endpoint.

// File: rtl/usb_rx_hs_pkg.sv
package usb_rx_hs_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } rx_stat_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned EPADDR_W = 4;
  localparam int unsigned CTRL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned STAT_LSB = 4;
endpackage

// File: rtl/usb_rx_ep_reg.sv
module usb_rx_ep_reg
  import usb_rx_hs_pkg::*;
#(
  parameter bit IS_EP0  = 1'b0,
  parameter bit PRESENT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rst_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hw_we_i,
  input  logic             hw_tog_i,
  input  logic             hw_nak_i,
  output logic [REG_W-1:0] q_o
);
  localparam logic [REG_W-1:0] RST_VAL = IS_EP0 ? 8'h80 : 8'h00;
  localparam logic [REG_W-1:0] KEEP_M  = IS_EP0 ? 8'h70 : 8'hFF;
  localparam logic [REG_W-1:0] FORCE_M = IS_EP0 ? 8'h80 : 8'h00;

  logic [REG_W-1:0] q, d;

  always_comb begin
    d = q;
    if (we_i) d = (wdata_i & KEEP_M) | FORCE_M;
    // hardware owns toggle/status on a completed transaction
    if (hw_we_i) begin
      d[TOG_BIT] = hw_tog_i;
      if (hw_nak_i) d[STAT_LSB +: 2] = ST_NAK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= RST_VAL;
    else if (bus_rst_i) q <= RST_VAL;
    else                q <= d;
  end

  assign q_o = PRESENT ? q : '0;
endmodule

// File: rtl/usb_rx_hs_decide.sv
module usb_rx_hs_decide
  import usb_rx_hs_pkg::*;
#(
  parameter int unsigned NUM_EP = 3,
  localparam int unsigned IW    = $clog2(NUM_EP)
) (
  input  logic [NUM_EP-1:0][REG_W-1:0] ep_q_i,
  input  logic [NUM_EP-1:0]            en_i,
  input  logic                         xact_end_i,
  input  logic                         setup_i,
  input  logic [EPADDR_W-1:0]          tok_ep_i,
  input  logic                         pid1_i,
  input  logic                         good_i,
  output hs_e                          hs_o,
  output logic [IW-1:0]                idx_o,
  output logic                         hw_we_o,
  output logic                         hw_tog_o,
  output logic                         hw_nak_o,
  output logic                         ctr_set_o
);
  logic             hit;
  logic [REG_W-1:0] sel;
  logic             ctrl, tog;
  rx_stat_e         stat;

  always_comb begin
    hit   = 1'b0;
    idx_o = '0;
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      if (en_i[i] && ep_q_i[i][EPADDR_W-1:0] == tok_ep_i) begin
        hit   = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  assign sel  = ep_q_i[idx_o];
  assign ctrl = sel[CTRL_BIT];
  assign tog  = sel[TOG_BIT];
  assign stat = rx_stat_e'(sel[STAT_LSB +: 2]);

  always_comb begin
    hs_o      = HS_NONE;
    hw_we_o   = 1'b0;
    hw_tog_o  = tog;
    hw_nak_o  = 1'b0;
    ctr_set_o = 1'b0;
    if (xact_end_i && hit && good_i) begin
      if (setup_i) begin
        // SETUP passes NAK/STALL on a control endpoint
        if (ctrl && stat != ST_OFF) begin
          hs_o    = HS_ACK;
          hw_we_o = 1'b1;
          if (!pid1_i) begin
            hw_tog_o  = 1'b1;
            hw_nak_o  = 1'b1;
            ctr_set_o = 1'b1;
          end else begin
            hw_tog_o = 1'b0;
          end
        end
      end else begin
        unique case (stat)
          ST_OFF:   hs_o = HS_NONE;
          ST_STALL: hs_o = HS_STALL;
          ST_NAK:   hs_o = HS_NAK;
          default: begin
            hs_o = HS_ACK;
            if (pid1_i == tog) begin
              hw_we_o   = 1'b1;
              hw_tog_o  = ~tog;
              hw_nak_o  = 1'b1;
              ctr_set_o = 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/usb_rx_hs_ctrl.sv
module usb_rx_hs_ctrl
  import usb_rx_hs_pkg::*;
#(
  parameter bit HAS_EP2 = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_rst_i,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       xact_end_i,
  input  logic       tok_setup_i,
  input  logic [3:0] tok_ep_i,
  input  logic       pid_data1_i,
  input  logic       pkt_good_i,
  output logic       hs_valid_o,
  output logic [1:0] hs_o,
  output logic [1:0] ep_idx_o,
  output logic       ctr_o
);
  localparam int unsigned NUM_EP = 3;
  localparam int unsigned IW     = $clog2(NUM_EP);
  localparam logic [NUM_EP-1:0] EP_EN = {HAS_EP2, 2'b11};

  logic [3:0][REG_W-1:0] ep_q;
  logic [NUM_EP*REG_W-1:0] ep_flat;
  hs_e           dec_hs;
  logic [IW-1:0] dec_idx;
  logic          hw_we, hw_tog, hw_nak, ctr_set;
  logic          ctr_q, hs_valid_q;
  hs_e           hs_q;
  logic [IW-1:0] idx_q;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    usb_rx_ep_reg #(
      .IS_EP0 (i == 0),
      .PRESENT(EP_EN[i])
    ) u_ep (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bus_rst_i(bus_rst_i),
      .we_i     (reg_we_i && reg_addr_i == 2'(i)),
      .wdata_i  (reg_wdata_i),
      .hw_we_i  (hw_we && dec_idx == IW'(i)),
      .hw_tog_i (hw_tog),
      .hw_nak_i (hw_nak),
      .q_o      (ep_q[i])
    );
  end
  assign ep_q[3]  = {7'b0, ctr_q};
  assign ep_flat  = ep_q[NUM_EP-1:0];

  usb_rx_hs_decide #(.NUM_EP(NUM_EP)) u_dec (
    .ep_q_i    (ep_q[NUM_EP-1:0]),
    .en_i      (EP_EN),
    .xact_end_i(xact_end_i),
    .setup_i   (tok_setup_i),
    .tok_ep_i  (tok_ep_i),
    .pid1_i    (pid_data1_i),
    .good_i    (pkt_good_i),
    .hs_o      (dec_hs),
    .idx_o     (dec_idx),
    .hw_we_o   (hw_we),
    .hw_tog_o  (hw_tog),
    .hw_nak_o  (hw_nak),
    .ctr_set_o (ctr_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q      <= 1'b0;
      hs_valid_q <= 1'b0;
      hs_q       <= HS_NONE;
      idx_q      <= '0;
    end else begin
      hs_valid_q <= xact_end_i;
      hs_q       <= dec_hs;
      idx_q      <= dec_idx;
      if (bus_rst_i)                          ctr_q <= 1'b0;
      else if (ctr_set)                       ctr_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == 2'd3) ctr_q <= 1'b0;
    end
  end

  assign reg_rdata_o = ep_q[reg_addr_i];
  assign hs_valid_o  = hs_valid_q;
  assign hs_o        = hs_q;
  assign ep_idx_o    = idx_q;
  assign ctr_o       = ctr_q;
endmodule

// File: rtl/usb_rx_hs_chk.sv
module usb_rx_hs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_rst_i,
  input logic [1:0]  reg_addr_i,
  input logic [7:0]  reg_rdata_o,
  input logic        xact_end_i,
  input logic        pkt_good_i,
  input logic        hs_valid_o,
  input logic [1:0]  hs_o,
  input logic [1:0]  ep_idx_o,
  input logic        ctr_o,
  input logic [23:0] ep_flat
);
  AST_EP0_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> (reg_rdata_o[7] && reg_rdata_o[3:0] == 4'h0)); // R2
  AST_HS_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> $past(xact_end_i)); // R3
  AST_CTR_PARKS_NAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctr_o) |-> (ep_flat[ep_idx_o*8 + 4 +: 2] == 2'b10)); // R4
  AST_CTR_ONLY_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctr_o) |-> (hs_valid_o && hs_o == 2'b01)); // R5
  AST_BAD_PKT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && !$past(pkt_good_i)) |-> (hs_o == 2'b00)); // R7
  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> (ep_idx_o != 2'd3)); // R8
  AST_BUSRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_rst_i) |-> !ctr_o); // R9
endmodule

bind usb_rx_hs_ctrl usb_rx_hs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_rst_i  (bus_rst_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .xact_end_i (xact_end_i),
  .pkt_good_i (pkt_good_i),
  .hs_valid_o (hs_valid_o),
  .hs_o       (hs_o),
  .ep_idx_o   (ep_idx_o),
  .ctr_o      (ctr_o),
  .ep_flat    (ep_flat)
);

// File: tb/usb_rx_hs_ctrl_bench.sv
module usb_rx_hs_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       xend = 1'b0;
  logic       setup = 1'b0;
  logic [3:0] tep = 4'd0;
  logic       pid1 = 1'b0;
  logic       good = 1'b0;

  logic [7:0] rdata, rdata_n;
  logic       hsv, hsv_n, ctr, ctr_n;
  logic [1:0] hs, hs_n, idx, idx_n;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  usb_rx_hs_ctrl u_usb_rx_hs_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .xact_end_i(xend), .tok_setup_i(setup), .tok_ep_i(tep),
    .pid_data1_i(pid1), .pkt_good_i(good),
    .hs_valid_o(hsv), .hs_o(hs), .ep_idx_o(idx), .ctr_o(ctr)
  );

  usb_rx_hs_ctrl #(.HAS_EP2(1'b0)) u_usb_rx_hs_ctrl_n2 (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_n),
    .xact_end_i(xend), .tok_setup_i(setup), .tok_ep_i(tep),
    .pid_data1_i(pid1), .pkt_good_i(good),
    .hs_valid_o(hsv_n), .hs_o(hs_n), .ep_idx_o(idx_n), .ctr_o(ctr_n)
  );

  // {wa, wd, setup, tep, pid1, good, exp_hs, exp_idx, exp_ctr, exp_reg}
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 8'h31, 1'b0, 4'd1, 1'b0, 1'b1, 2'd1, 2'd1, 1'b1, 8'h61}, // R4
    {2'd1, 8'h71, 1'b0, 4'd1, 1'b0, 1'b1, 2'd1, 2'd1, 1'b0, 8'h71}, // R5
    {2'd1, 8'h21, 1'b0, 4'd1, 1'b0, 1'b1, 2'd2, 2'd1, 1'b0, 8'h21}, // R3 nak
    {2'd1, 8'h11, 1'b0, 4'd1, 1'b0, 1'b1, 2'd3, 2'd1, 1'b0, 8'h11}, // R3 stall
    {2'd1, 8'h01, 1'b0, 4'd1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 8'h01}, // R3 off
    {2'd1, 8'h31, 1'b0, 4'd1, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 8'h31}, // R7
    {2'd2, 8'h32, 1'b0, 4'd2, 1'b0, 1'b1, 2'd1, 2'd2, 1'b1, 8'h62}, // R8
    {2'd2, 8'h33, 1'b0, 4'd5, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 8'h33}, // R8 no match
    {2'd0, 8'h30, 1'b0, 4'd0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 8'hE0}, // R2 R4
    {2'd0, 8'h50, 1'b1, 4'd0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 8'hE0}, // R6 stall
    {2'd0, 8'h70, 1'b1, 4'd0, 1'b1, 1'b1, 2'd1, 2'd0, 1'b0, 8'hB0}, // R6 data1
    {2'd1, 8'h31, 1'b1, 4'd1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 8'h31}, // R6 non-ctrl
    {2'd1, 8'hB1, 1'b1, 4'd1, 1'b0, 1'b1, 2'd1, 2'd1, 1'b1, 8'hE1}, // R6 ctrl
    {2'd2, 8'h31, 1'b0, 4'd1, 1'b0, 1'b1, 2'd2, 2'd1, 1'b0, 8'h31}  // R8 priority
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic xact(input logic s, input logic [3:0] e, input logic p, input logic g);
    @(negedge clk);
    xend = 1'b1; setup = s; tep = e; pid1 = p; good = g;
    @(negedge clk);
    xend = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 2'd0; #1 chk("R1 ep0", rdata, 8'h80);
    addr = 2'd1; #1 chk("R1 ep1", rdata, 8'h00);
    addr = 2'd2; #1 chk("R1 ep2", rdata, 8'h00);
    addr = 2'd3; #1 chk("R1 flag", rdata, 8'h00);
    chk("R1 hs_valid", {7'b0, hsv}, 8'h00);

    wr(2'd0, 8'h0F);
    addr = 2'd0; #1 chk("R2 ep0 fixed bits", rdata, 8'h80);

    for (int v = 0; v < NV; v++) begin
      logic [29:0] e;
      e = VEC[v];
      wr(2'd3, 8'h00);
      wr(e[29:28], e[27:20]);
      xact(e[19], e[18:15], e[14], e[13]);
      addr = e[29:28];
      #1;
      chk($sformatf("R3 vec%0d valid", v), {7'b0, hsv}, 8'h01);
      chk($sformatf("R3 vec%0d hs", v), {6'b0, hs}, {6'b0, e[12:11]});
      chk($sformatf("R8 vec%0d idx", v), {6'b0, idx}, {6'b0, e[10:9]});
      chk($sformatf("R4 vec%0d ctr", v), {7'b0, ctr}, {7'b0, e[8]});
      chk($sformatf("R5 vec%0d reg", v), rdata, e[7:0]);
      @(negedge clk);
      chk($sformatf("R3 vec%0d pulse", v), {7'b0, hsv}, 8'h00);
    end

    // R10: write and hardware update in one cycle
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h31);
    @(negedge clk);
    we = 1'b1; addr = 2'd1; wdata = 8'h15;
    xend = 1'b1; setup = 1'b0; tep = 4'd1; pid1 = 1'b0; good = 1'b1;
    @(negedge clk);
    we = 1'b0; xend = 1'b0;
    #1 chk("R10 merged word", rdata, 8'h65);
    chk("R10 hs", {6'b0, hs}, 8'h01);

    // R11: sticky flag, set beats clear
    addr = 2'd3; #1 chk("R11 flag read", rdata, 8'h01);
    wr(2'd1, 8'h35);
    @(negedge clk);
    we = 1'b1; addr = 2'd3; wdata = 8'h00;
    xend = 1'b1; setup = 1'b0; tep = 4'd5; pid1 = 1'b0; good = 1'b1;
    @(negedge clk);
    we = 1'b0; xend = 1'b0;
    #1 chk("R11 set wins", {7'b0, ctr}, 8'h01);
    repeat (2) @(negedge clk);
    chk("R11 held", {7'b0, ctr}, 8'h01);
    wr(2'd3, 8'hFF);
    addr = 2'd3; #1 chk("R11 cleared", rdata, 8'h00);

    // R9: bus reset
    wr(2'd1, 8'h31);
    xact(1'b0, 4'd1, 1'b0, 1'b1);
    chk("R9 pre flag", {7'b0, ctr}, 8'h01);
    wr(2'd2, 8'h3A);
    @(negedge clk);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    chk("R9 flag", {7'b0, ctr}, 8'h00);
    addr = 2'd0; #1 chk("R9 ep0", rdata, 8'h80);
    addr = 2'd1; #1 chk("R9 ep1", rdata, 8'h00);
    addr = 2'd2; #1 chk("R9 ep2", rdata, 8'h00);

    // R12: build without third endpoint
    wr(2'd2, 8'h32);
    addr = 2'd2; #1 chk("R12 ep2 absent reads 0", rdata_n, 8'h00);
    chk("R12 ep2 present", rdata, 8'h32);
    xact(1'b0, 4'd2, 1'b0, 1'b1);
    chk("R12 full hs", {6'b0, hs}, 8'h01);
    chk("R12 full idx", {6'b0, idx}, 8'h02);
    chk("R12 absent valid", {7'b0, hsv_n}, 8'h01);
    chk("R12 absent hs none", {6'b0, hs_n}, 8'h00);
    chk("R12 absent ctr", {7'b0, ctr_n}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule